// File: doc/BRIEF.md
# Weighted Score Output Channel Selector

This block sits after the adaptive route computation of a mesh router and decides which of the four mesh directions a header flit leaves through. The route function supplies a candidate mask. The reservation table supplies a mask of channels already held by other headers. Only candidates that are not reserved are eligible. For each direction the block also receives three figures: a link selection probability, the free slot count in the neighbour's input buffer, and the recent change in router power.

Each eligible direction is scored with three programmable weights. The score adds the weighted probability and the weighted normalised buffer space, and subtracts the weighted normalised power change. The eligible direction with the largest score is granted as a one-hot vector, together with a valid flag, one clock after the header is presented. Both normalisations use a constant reciprocal multiply, so the block contains no divider.

Top module: `chan_score_sel`

## Requirements
- R1: While `rst_n` is low, and on the first clock after reset, `grant` is 4'b0000 and `grant_valid` is 0.
- R2: A direction can be granted only if its `cand_mask` bit is 1 and its `resv_mask` bit is 0. A reserved candidate is never granted, even when its score is the highest. Lane d of every mask and vector is direction d, with N=0, E=1, S=2 and W=3.
- R3: Let F=FRAC (default 8). The normalised buffer term is floor(free * floor(2^(2F)/MAX_BUF) / 2^F), and it saturates at 2^F when it would exceed that value. The power term is formed the same way from `dpwr` with MAX_PWR. The probability is used as given, without normalisation.
- R4: The score is the signed value wt_prob*prob + wt_buf*bufnorm - wt_pwr*pwrnorm. The grant is one-hot on the eligible direction with the largest score.
- R5: When several eligible directions share the top score, the grant goes to the first of them in the order N, E, S, W.
- R6: If no direction is eligible, the next clock gives `grant_valid` = 0 and `grant` = 0.
- R7: A header sampled with `hdr_valid`=1 produces its grant and `grant_valid`=1 exactly one clock later. A clock edge with `hdr_valid`=0 produces `grant_valid`=0 and `grant`=0 on the next cycle.
- R8: Weights and probabilities are unsigned, FRAC+1 bits wide, with F fractional bits. The value 1.0 is 256, 0.3 is 77 and 0.4 is 102. A change of weights alters the choice made for the next header.
- R9: Scores are compared as signed values, so the least negative score wins when all eligible scores are below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | A header requests a direction this cycle |
| cand_mask | input | 4 | Directions offered by the route function |
| resv_mask | input | 4 | Directions held in the reservation table |
| prob_vec | input | 4*(FRAC+1) | Per-direction link selection probability |
| free_vec | input | 4*BUF_W | Per-direction free slots in the neighbour buffer |
| dpwr_vec | input | 4*PWR_W | Per-direction instantaneous power change |
| wt_prob | input | FRAC+1 | Weight of the probability term |
| wt_buf | input | FRAC+1 | Weight of the buffer term |
| wt_pwr | input | FRAC+1 | Weight of the power term |
| grant | output | 4 | One-hot chosen direction |
| grant_valid | output | 1 | A direction was chosen |

## Verification
The bench builds the block with MAX_BUF=12 and MAX_PWR=64. MAX_BUF=12 makes the buffer reciprocal inexact, so the truncation in the normalisation decides a tie that exact division would not. A free count above 12 fits in the 5-bit field and so exercises the saturation. MAX_PWR=64 keeps the power term a plain multiply by four. Under these settings the tests can pick vectors where a single term decides the winner, reach scores that are entirely negative, and build exact ties that depend only on the direction order.

// File: rtl/csel_pkg.sv
package csel_pkg;
   localparam int NDIR = 4;
   // lane index of each direction; the lane order is also the tie-break order
   typedef enum logic [1:0] {
      DIR_N = 2'd0,
      DIR_E = 2'd1,
      DIR_S = 2'd2,
      DIR_W = 2'd3
   } dir_e;
   localparam int DIR_W_IDX = $clog2(NDIR);
endpackage

// File: rtl/csel_norm.sv
module csel_norm #(
   parameter int IN_W  = 5,
   parameter int MAXV  = 16,
   parameter int FRAC  = 8,
   parameter bit ROUND = 1'b0
) (
   input  logic [IN_W-1:0] raw,
   output logic [FRAC:0]   norm
);
   localparam int RECIP = (1 << (2*FRAC)) / MAXV;
   localparam int RW    = 2*FRAC + 1;
   localparam int PW    = IN_W + RW;

   logic [PW-1:0] prod, adj, scaled;

   assign prod = PW'(raw) * PW'(RECIP);

   generate
      if (ROUND) begin : g_round
         assign adj = prod + PW'(1 << (FRAC-1));
      end else begin : g_trunc
         assign adj = prod;
      end
   endgenerate

   assign scaled = adj >> FRAC;
   assign norm   = (scaled > PW'(1 << FRAC)) ? (FRAC+1)'(1 << FRAC) : scaled[FRAC:0];
endmodule

// File: rtl/csel_score.sv
module csel_score #(
   parameter int FRAC    = 8,
   parameter int BUF_W   = 5,
   parameter int PWR_W   = 8,
   parameter int MAX_BUF = 16,
   parameter int MAX_PWR = 255,
   parameter bit ROUND   = 1'b0,
   localparam int PD     = 2*(FRAC+1),
   localparam int SW     = PD + 1
) (
   input  logic [FRAC:0]        prob,
   input  logic [BUF_W-1:0]     free_cnt,
   input  logic [PWR_W-1:0]     dpwr,
   input  logic [FRAC:0]        wt_prob,
   input  logic [FRAC:0]        wt_buf,
   input  logic [FRAC:0]        wt_pwr,
   output logic signed [SW-1:0] score
);
   logic [FRAC:0] buf_n, pwr_n;
   logic [PD-1:0] t_prob, t_buf, t_pwr;

   csel_norm #(.IN_W(BUF_W), .MAXV(MAX_BUF), .FRAC(FRAC), .ROUND(ROUND)) u_nbuf (
      .raw(free_cnt), .norm(buf_n));
   csel_norm #(.IN_W(PWR_W), .MAXV(MAX_PWR), .FRAC(FRAC), .ROUND(ROUND)) u_npwr (
      .raw(dpwr), .norm(pwr_n));

   assign t_prob = PD'(wt_prob) * PD'(prob);
   assign t_buf  = PD'(wt_buf)  * PD'(buf_n);
   assign t_pwr  = PD'(wt_pwr)  * PD'(pwr_n);

   assign score = $signed({1'b0, t_prob}) + $signed({1'b0, t_buf}) - $signed({1'b0, t_pwr});
endmodule

// File: rtl/csel_argmax.sv
module csel_argmax #(
   parameter int NDIR = 4,
   parameter int SW   = 19,
   localparam int IW  = $clog2(NDIR)
) (
   input  logic signed [SW-1:0] score [NDIR],
   input  logic [NDIR-1:0]      elig,
   output logic [NDIR-1:0]      win_oh,
   output logic [IW-1:0]        win_idx,
   output logic                 any
);
   logic signed [SW-1:0] best;

   // ascending scan with strict compare: the lowest lane keeps a tie
   always_comb begin
      best    = '0;
      win_idx = '0;
      any     = 1'b0;
      for (int i = 0; i < NDIR; i++) begin
         if (elig[i] && (!any || score[i] > best)) begin
            best    = score[i];
            win_idx = IW'(i);
            any     = 1'b1;
         end
      end
      win_oh = any ? (NDIR'(1) << win_idx) : '0;
   end
endmodule

// File: rtl/chan_score_sel.sv
module chan_score_sel
   import csel_pkg::*;
#(
   parameter int FRAC    = 8,
   parameter int BUF_W   = 5,
   parameter int PWR_W   = 8,
   parameter int MAX_BUF = 16,
   parameter int MAX_PWR = 255,
   parameter bit ROUND   = 1'b0,
   localparam int PB     = FRAC + 1,
   localparam int SW     = 2*PB + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hdr_valid,
   input  logic [NDIR-1:0]       cand_mask,
   input  logic [NDIR-1:0]       resv_mask,
   input  logic [NDIR*PB-1:0]    prob_vec,
   input  logic [NDIR*BUF_W-1:0] free_vec,
   input  logic [NDIR*PWR_W-1:0] dpwr_vec,
   input  logic [PB-1:0]         wt_prob,
   input  logic [PB-1:0]         wt_buf,
   input  logic [PB-1:0]         wt_pwr,
   output logic [NDIR-1:0]       grant,
   output logic                  grant_valid
);
   // elaboration-time parameter checks
   generate
      if (FRAC < 2 || FRAC > 12) begin : g_bad_frac
         $error("FRAC out of range");
      end
      if (MAX_BUF < 1 || MAX_BUF > (1 << BUF_W) - 1) begin : g_bad_buf
         $error("MAX_BUF must be 1..2^BUF_W-1");
      end
      if (MAX_PWR < 1 || MAX_PWR > (1 << PWR_W) - 1) begin : g_bad_pwr
         $error("MAX_PWR must be 1..2^PWR_W-1");
      end
   endgenerate

   logic [NDIR-1:0]      elig;
   logic signed [SW-1:0] score [NDIR];
   logic [NDIR-1:0]      win_oh;
   logic [DIR_W_IDX-1:0] win_idx;
   logic                 any_elig;

   assign elig = cand_mask & ~resv_mask;

   generate
      for (genvar d = 0; d < NDIR; d++) begin : g_dir
         csel_score #(
            .FRAC(FRAC), .BUF_W(BUF_W), .PWR_W(PWR_W),
            .MAX_BUF(MAX_BUF), .MAX_PWR(MAX_PWR), .ROUND(ROUND)
         ) u_score (
            .prob    (prob_vec[d*PB +: PB]),
            .free_cnt(free_vec[d*BUF_W +: BUF_W]),
            .dpwr    (dpwr_vec[d*PWR_W +: PWR_W]),
            .wt_prob (wt_prob),
            .wt_buf  (wt_buf),
            .wt_pwr  (wt_pwr),
            .score   (score[d])
         );
      end
   endgenerate

   csel_argmax #(.NDIR(NDIR), .SW(SW)) u_arb (
      .score  (score),
      .elig   (elig),
      .win_oh (win_oh),
      .win_idx(win_idx),
      .any    (any_elig)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant       <= '0;
         grant_valid <= 1'b0;
      end else if (hdr_valid) begin
         grant       <= win_oh;
         grant_valid <= any_elig;
      end else begin
         grant       <= '0;
         grant_valid <= 1'b0;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R4
   AST_VALID_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> grant != '0); // R6
   AST_GRANT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |-> grant == '0); // R6
   AST_ELIGIBLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_valid |=> (grant & ~$past(elig)) == '0); // R2
   AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && elig == '0) |=> !grant_valid); // R6
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && elig != '0) |=> grant_valid); // R7
   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !hdr_valid |=> !grant_valid); // R7

   generate
      for (genvar d = 0; d < NDIR; d++) begin : g_chk
         AST_TOP_SCORE: assert property (@(posedge clk) disable iff (!rst_n)
            (any_elig && elig[d]) |-> score[d] <= score[win_idx]); // R4
         AST_TIE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            (any_elig && elig[d] && DIR_W_IDX'(d) < win_idx) |-> score[d] < score[win_idx]); // R5
      end
   endgenerate
endmodule

// File: tb/chan_score_sel_tb.sv
module chan_score_sel_tb;
   localparam int FRAC = 8;
   localparam int PB   = FRAC + 1;
   localparam int BW   = 5;
   localparam int PWW  = 8;
   localparam int MXB  = 12;
   localparam int MXP  = 64;

   typedef struct packed {
      logic [3:0]          cand;
      logic [3:0]          resv;
      logic [3:0][PB-1:0]  prob;  // {W,S,E,N}
      logic [3:0][BW-1:0]  free;
      logic [3:0][PWW-1:0] pwr;
      logic [3:0]          egnt;
   } row_t;

   localparam int NROW = 11;
   localparam row_t TAB [NROW] = '{
      '{4'b1111, 4'b0000, {9'd100,9'd100,9'd100,9'd100}, {5'd3,5'd3,5'd12,5'd3}, {8'd5,8'd5,8'd5,8'd5}, 4'b0010},
      '{4'b1111, 4'b0010, {9'd100,9'd100,9'd100,9'd100}, {5'd3,5'd3,5'd12,5'd3}, {8'd5,8'd5,8'd5,8'd5}, 4'b0001},
      '{4'b1100, 4'b0000, {9'd200,9'd50,9'd0,9'd0},      {5'd6,5'd6,5'd6,5'd6},  {8'd0,8'd0,8'd0,8'd0}, 4'b1000},
      '{4'b1111, 4'b0000, {9'd80,9'd80,9'd80,9'd80},     {5'd6,5'd6,5'd6,5'd6},  {8'd10,8'd10,8'd10,8'd10}, 4'b0001},
      '{4'b1111, 4'b1111, {9'd80,9'd80,9'd80,9'd80},     {5'd6,5'd6,5'd6,5'd6},  {8'd10,8'd10,8'd10,8'd10}, 4'b0000},
      '{4'b1111, 4'b0000, {9'd80,9'd80,9'd80,9'd80},     {5'd6,5'd6,5'd6,5'd6},  {8'd10,8'd10,8'd10,8'd60}, 4'b0010},
      '{4'b0100, 4'b0000, {9'd255,9'd0,9'd255,9'd255},   {5'd12,5'd0,5'd12,5'd12}, {8'd0,8'd63,8'd0,8'd0}, 4'b0100},
      '{4'b1100, 4'b0100, {9'd0,9'd255,9'd0,9'd0},       {5'd0,5'd12,5'd0,5'd0}, {8'd0,8'd0,8'd0,8'd0}, 4'b1000},
      '{4'b1111, 4'b0000, {9'd0,9'd0,9'd0,9'd0},         {5'd0,5'd0,5'd0,5'd0},  {8'd60,8'd10,8'd60,8'd60}, 4'b0100},
      '{4'b0000, 4'b0000, {9'd80,9'd80,9'd80,9'd80},     {5'd6,5'd6,5'd6,5'd6},  {8'd10,8'd10,8'd10,8'd10}, 4'b0000},
      '{4'b0011, 4'b0000, {9'd0,9'd0,9'd0,9'd0},         {5'd0,5'd0,5'd31,5'd20}, {8'd0,8'd0,8'd0,8'd0}, 4'b0001}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           hdr_valid = 1'b0;
   logic [3:0]     cand_mask = '0, resv_mask = '0;
   logic [4*PB-1:0]  prob_vec = '0;
   logic [4*BW-1:0]  free_vec = '0;
   logic [4*PWW-1:0] dpwr_vec = '0;
   logic [PB-1:0]  wt_prob = 9'd77, wt_buf = 9'd102, wt_pwr = 9'd77;
   logic [3:0]     grant;
   logic           grant_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   chan_score_sel #(.FRAC(FRAC), .BUF_W(BW), .PWR_W(PWW), .MAX_BUF(MXB), .MAX_PWR(MXP)) u_dut (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
      .cand_mask(cand_mask), .resv_mask(resv_mask),
      .prob_vec(prob_vec), .free_vec(free_vec), .dpwr_vec(dpwr_vec),
      .wt_prob(wt_prob), .wt_buf(wt_buf), .wt_pwr(wt_pwr),
      .grant(grant), .grant_valid(grant_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int nrm(input int v, input int mx);
      int r;
      r = (v * ((1 << (2*FRAC)) / mx)) >> FRAC;
      return (r > (1 << FRAC)) ? (1 << FRAC) : r;
   endfunction

   function automatic logic [3:0] model(input row_t r);
      int best, sc;
      logic [3:0] g;
      g = '0;
      best = 0;
      for (int d = 0; d < 4; d++) begin
         if (r.cand[d] && !r.resv[d]) begin
            sc = int'(wt_prob) * int'(r.prob[d]) + int'(wt_buf) * nrm(int'(r.free[d]), MXB)
               - int'(wt_pwr) * nrm(int'(r.pwr[d]), MXP);
            if (g == '0 || sc > best) begin
               best = sc;
               g = 4'b0001 << d;
            end
         end
      end
      return g;
   endfunction

   task automatic drive(input row_t r);
      cand_mask = r.cand;
      resv_mask = r.resv;
      prob_vec  = r.prob;
      free_vec  = r.free;
      dpwr_vec  = r.pwr;
   endtask

   // present one header at a negedge, read the grant one clock later
   task automatic send(input row_t r, input string req);
      @(negedge clk);
      drive(r);
      hdr_valid = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      chk({req, " grant"}, int'(grant), int'(r.egnt));
      chk({req, " valid"}, int'(grant_valid), int'(r.egnt != 4'b0000));
   endtask

   function automatic row_t mk(input logic [3:0] c, input logic [8:0] pn, input logic [8:0] pe,
                               input logic [4:0] fn, input logic [4:0] fe, input logic [3:0] e);
      row_t r;
      r.cand = c;
      r.resv = '0;
      r.prob = {9'd0, 9'd0, pe, pn};
      r.free = {5'd0, 5'd0, fe, fn};
      r.pwr  = '0;
      r.egnt = e;
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      row_t r;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 grant in reset", int'(grant), 0);
      chk("R1 valid in reset", int'(grant_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", int'(grant_valid), 0);

      // table walk: R2 R4 R5 R6 R9 R3 (saturation in last row)
      for (int i = 0; i < NROW; i++) begin
         send(TAB[i], $sformatf("R2/R4/R5/R6/R9 row %0d", i));
         chk($sformatf("R4 model row %0d", i), int'(model(TAB[i])), int'(TAB[i].egnt));
      end

      // R7: no grant before the edge, grant one edge later, cleared when idle
      @(negedge clk);
      drive(TAB[0]);
      hdr_valid = 1'b1;
      #1;
      chk("R7 valid before edge", int'(grant_valid), 0);
      @(negedge clk);
      hdr_valid = 1'b0;
      chk("R7 valid after one edge", int'(grant_valid), 1);
      @(negedge clk);
      chk("R7 valid idle", int'(grant_valid), 0);
      chk("R7 grant idle", int'(grant), 0);

      // R8: weights decide between probability and buffer space
      wt_prob = 9'd256; wt_buf = 9'd77; wt_pwr = 9'd77;
      send(mk(4'b1111, 9'd256, 9'd0, 5'd0, 5'd12, 4'b0001), "R8 prob weight 1.0");
      wt_prob = 9'd77; wt_buf = 9'd102;
      send(mk(4'b1111, 9'd256, 9'd0, 5'd0, 5'd12, 4'b0010), "R8 weights 0.3/0.4/0.3");

      // R3: truncated reciprocal, free=1 of 12 normalises to 21
      wt_prob = 9'd256; wt_buf = 9'd256; wt_pwr = 9'd0;
      send(mk(4'b0011, 9'd21, 9'd0, 5'd0, 5'd1, 4'b0001), "R3 truncation tie");
      send(mk(4'b0011, 9'd20, 9'd0, 5'd0, 5'd1, 4'b0010), "R3 truncation below");

      // R8: power weight alone, lowest power change wins
      wt_prob = 9'd0; wt_buf = 9'd0; wt_pwr = 9'd256;
      r = TAB[3];
      r.pwr  = {8'd30, 8'd40, 8'd20, 8'd50};
      r.egnt = 4'b0010;
      send(r, "R8 power only");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule